// File: doc/BRIEF.md
# Word-Level Run-Length Loss Detector

This block watches the parallel words that a deserializer produces and raises a loss-of-signal flag when the line appears stuck. It does not count bits. It counts whole words. A word is "uniform" when every bit in it has the same value. The flag rises once enough consecutive uniform words of the same polarity have arrived. A lock controller downstream uses the flag to pull its oscillator back onto the reference clock.

Because the check only sees whole words, the detectable bit run is fuzzy. With a limit of 12 ten-bit words, a stuck stretch must span 12 complete words. Any run of 129 bits or more does so, whatever its alignment. No run of 119 bits or fewer can do so. Runs in between are caught or missed depending on where they start inside a word.

The word width and the word-count limit are parameters. Words are offered with a valid strobe on the word clock. Cycles with the strobe low leave the state untouched.

Top module: `rlLossDetect`

## Requirements
- R1: While the active-low reset is asserted, `sigLoss` is 0 and the run count is cleared, so that after release a full 12-word run is needed to raise the flag.
- R2: A valid word is uniform when all of its 10 bits are 1 (0x3FF) or all are 0 (0x000). Any other value is a mixed word.
- R3: `sigLoss` rises at the clock edge that accepts the 12th consecutive valid uniform word of one polarity. After only 11 such words it is still 0.
- R4: Once raised, `sigLoss` stays 1 while further valid uniform words of the same polarity arrive. The count saturates at 12 and does not wrap.
- R5: A valid mixed word clears the count and drops `sigLoss` at the edge that accepts it.
- R6: A valid uniform word whose polarity differs from the previous valid uniform word restarts the count at 1. After 11 words of one value followed by 11 words of the other, `sigLoss` is 0; the 12th word of the new value raises it.
- R7: Cycles with `wordValid` low have no effect. `sigLoss` holds, and the count neither advances nor resets, so a run split by idle cycles still completes.
- R8: When a serial stream is cut into words with bit 0 first, a run of 119 or fewer identical bits bounded by opposite bits never raises `sigLoss`, for any start offset 0 to 9 within a word.
- R9: A run of 129 or more identical bits always raises `sigLoss`, for any start offset.
- R10: A run of 120 to 128 bits raises `sigLoss` exactly when it covers 12 complete words. For example, 120 bits starting at offset 0 raise it, and 120 bits starting at offset 1 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | Qualifies `wordData` in this cycle |
| wordData | input | WORD_W (10) | Parallel word from the deserializer |
| sigLoss | output | 1 | Loss-of-signal flag to the lock controller |

## Verification
The bound checker checks the following on every cycle:
- `sigLoss` is held low under reset.
- A mixed word always drops the flag.
- Idle cycles never move the flag.
- The flag only rises right after a uniform word.
- A same-polarity uniform word keeps the flag up.
- A change of polarity always drops the flag.

The exact word count at which the flag rises can only be shown by the bench's scenarios. The same holds for the 119/120–128/129-bit band across all ten alignments. The bench cuts synthetic serial streams into words to show that band.

// File: rtl/rlPkg.sv
package rlPkg;
  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic advance;   // same-polarity uniform word: count up (saturating)
    logic restart;   // uniform word of a new polarity: count becomes 1
    logic clear;     // mixed word: count becomes 0
  } rlCtrl_t;

  typedef enum logic [1:0] {
    POL_NONE  = 2'd0,
    POL_ONES  = 2'd1,
    POL_ZEROS = 2'd2
  } rlPol_e;
endpackage

// File: rtl/rlDatapath.sv
module rlDatapath
  import rlPkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordData,
  input  rlCtrl_t           ctrl,
  output logic              isOnes,
  output logic              isZeros,
  output logic              sigLoss
);
  localparam int CNT_W = $clog2(RUN_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_WORDS);

  logic [CNT_W-1:0] runCount;

  // Word classification
  assign isOnes  = &wordData;
  assign isZeros = ~|wordData;

  // Saturating run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (ctrl.clear) begin
      runCount <= '0;
    end else if (ctrl.restart) begin
      runCount <= CNT_W'(1);
    end else if (ctrl.advance && (runCount != CNT_MAX)) begin
      runCount <= runCount + CNT_W'(1);
    end
  end

  assign sigLoss = (runCount == CNT_MAX);
endmodule

// File: rtl/rlControl.sv
module rlControl
  import rlPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wordValid,
  input  logic    isOnes,
  input  logic    isZeros,
  output rlCtrl_t ctrl
);
  rlPol_e polState, polNext;

  always_comb begin
    ctrl    = '0;
    polNext = polState;
    if (wordValid) begin
      if (isOnes) begin
        if (polState == POL_ONES) ctrl.advance = 1'b1;
        else                      ctrl.restart = 1'b1;
        polNext = POL_ONES;
      end else if (isZeros) begin
        if (polState == POL_ZEROS) ctrl.advance = 1'b1;
        else                       ctrl.restart = 1'b1;
        polNext = POL_ZEROS;
      end else begin
        ctrl.clear = 1'b1;
        polNext    = POL_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) polState <= POL_NONE;
    else       polState <= polNext;
  end
endmodule

// File: rtl/rlLossDetect.sv
module rlLossDetect
  import rlPkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              sigLoss
);
  rlCtrl_t ctrl;
  logic    isOnes;
  logic    isZeros;

  rlControl u_control (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .isOnes    (isOnes),
    .isZeros   (isZeros),
    .ctrl      (ctrl)
  );

  rlDatapath #(
    .WORD_W    (WORD_W),
    .RUN_WORDS (RUN_WORDS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .wordData (wordData),
    .ctrl     (ctrl),
    .isOnes   (isOnes),
    .isZeros  (isZeros),
    .sigLoss  (sigLoss)
  );
endmodule

// File: rtl/rlLossDetect_chk.sv
module rlLossDetect_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordData,
  input logic              sigLoss
);
  logic uniformNow;
  assign uniformNow = (wordData == '0) || (wordData == '1);

  // Last valid uniform word, for polarity comparisons
  logic [WORD_W-1:0] lastUni;
  logic              haveUni;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastUni <= '0;
      haveUni <= 1'b0;
    end else if (wordValid) begin
      haveUni <= uniformNow;
      lastUni <= wordData;
    end
  end

  // R1: flag is low under reset
  a_r1_reset_low: assert property (@(posedge clk) !rstN |-> !sigLoss);

  // R5: a mixed word drops the flag
  a_r5_mixed_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !uniformNow) |=> !sigLoss);

  // R7: idle cycles leave the flag unchanged
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(sigLoss));

  // R3: the flag only rises right after a valid uniform word
  a_r3_rise_after_uniform: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sigLoss) |-> ($past(wordValid) &&
                        (($past(wordData) == '0) || ($past(wordData) == '1))));

  // R4: a same-polarity uniform word keeps a raised flag up
  a_r4_saturate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sigLoss && wordValid && uniformNow && haveUni && wordData == lastUni) |=> sigLoss);

  // R6: a change of polarity drops the flag
  a_r6_polarity_restart: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && uniformNow && haveUni && wordData != lastUni) |=> !sigLoss);
endmodule

bind rlLossDetect rlLossDetect_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wordValid (wordValid),
  .wordData  (wordData),
  .sigLoss   (sigLoss)
);

// File: tb/rlLossDetect_bench.sv
module rlLossDetect_bench;
  localparam int W = 10;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wordValid = 1'b0;
  logic [W-1:0] wordData = '0;
  logic         sigLoss;

  int checks = 0;
  int fails  = 0;
  logic lossSeen;

  localparam logic [W-1:0] ONES  = 10'h3FF;
  localparam logic [W-1:0] ZEROS = 10'h000;
  localparam logic [W-1:0] MIXED = 10'h155;

  rlLossDetect #(.WORD_W(W), .RUN_WORDS(N)) u_rlLossDetect (
    .clk(clk), .rstN(rstN), .wordValid(wordValid),
    .wordData(wordData), .sigLoss(sigLoss)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sigLoss=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Offer one word; return 2 ns after the accepting edge.
  task automatic sendWord(input logic [W-1:0] d);
    wordValid = 1'b1;
    wordData  = d;
    @(posedge clk); #2;
    wordValid = 1'b0;
    lossSeen  = lossSeen | sigLoss;
  endtask

  task automatic idle(input int n);
    wordValid = 1'b0;
    wordData  = ONES;
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic sendRun(input logic [W-1:0] d, input int n);
    for (int i = 0; i < n; i++) sendWord(d);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    idle(3);
    check("R1 reset", sigLoss, 1'b0);
    rstN = 1'b1;
    idle(1);
    sendRun(ONES, N - 1);
    check("R1 count cleared after reset", sigLoss, 1'b0);
    sendWord(MIXED);
  endtask

  task automatic testThreshold();
    sendRun(ONES, N - 1);
    check("R3 11 ones", sigLoss, 1'b0);
    sendWord(ONES);
    check("R3 12th ones word", sigLoss, 1'b1);
    sendWord(MIXED);
    sendRun(ZEROS, N - 1);
    check("R3/R2 11 zeros", sigLoss, 1'b0);
    sendWord(ZEROS);
    check("R3/R2 12th zeros word", sigLoss, 1'b1);
    sendWord(MIXED);
  endtask

  task automatic testSaturate();
    sendRun(ONES, N + 20);
    check("R4 saturate hold", sigLoss, 1'b1);
    sendWord(MIXED);
    check("R5 mixed clears", sigLoss, 1'b0);
    sendRun(ONES, N - 1);
    check("R5 count cleared by mixed", sigLoss, 1'b0);
    sendWord(10'h3FE);
    check("R2 one zero bit is mixed", sigLoss, 1'b0);
    sendRun(ONES, N - 1);
    check("R2 count restarted after 0x3FE", sigLoss, 1'b0);
    sendWord(MIXED);
  endtask

  task automatic testPolarity();
    sendRun(ONES, N - 1);
    sendRun(ZEROS, N - 1);
    check("R6 11 ones then 11 zeros", sigLoss, 1'b0);
    sendWord(ZEROS);
    check("R6 12th zeros word", sigLoss, 1'b1);
    sendWord(ONES);
    check("R6 switch drops flag", sigLoss, 1'b0);
    sendWord(MIXED);
  endtask

  task automatic testIdle();
    sendRun(ONES, 6);
    idle(5);
    sendRun(ONES, 5);
    idle(3);
    check("R7 idle no advance", sigLoss, 1'b0);
    sendWord(ONES);
    check("R7 split run completes", sigLoss, 1'b1);
    idle(7);
    check("R7 idle holds flag", sigLoss, 1'b1);
    sendWord(MIXED);
  endtask

  // Serial run of len bits of value v starting at bit offset off within a word.
  task automatic bitRun(input string req, input int len, input int off, input logic v);
    logic bits [0:199];
    int   pre;
    int   total;
    int   whole;
    int   lead;
    logic expLoss;
    pre = W + off;
    total = pre + len;
    total = ((total + W - 1) / W) * W + 2 * W;
    for (int i = 0; i < pre; i++) bits[i] = (((pre - 1 - i) % 2) == 0) ? ~v : v;
    for (int i = 0; i < len; i++) bits[pre + i] = v;
    for (int i = pre + len; i < total; i++) bits[i] = (((i - pre - len) % 2) == 0) ? ~v : v;
    lossSeen = 1'b0;
    for (int k = 0; k < total / W; k++) begin
      logic [W-1:0] w;
      for (int b = 0; b < W; b++) w[b] = bits[k * W + b];
      sendWord(w);
    end
    lead = (W - off) % W;
    whole = (len - lead) / W;
    expLoss = (whole >= N);
    check($sformatf("%s len=%0d off=%0d v=%0b", req, len, off, v), lossSeen, expLoss);
    check($sformatf("%s cleared after stream", req), sigLoss, 1'b0);
  endtask

  task automatic testBitRuns();
    for (int off = 0; off < W; off++) begin
      bitRun("R8", 119, off, 1'b1);
      bitRun("R8", 119, off, 1'b0);
      bitRun("R9", 129, off, 1'b0);
      bitRun("R9", 129, off, 1'b1);
      bitRun("R10", 120, off, 1'b1);
      bitRun("R10", 125, off, 1'b0);
      bitRun("R10", 128, off, 1'b1);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    lossSeen = 1'b0;
    testReset();
    testThreshold();
    testSaturate();
    testPolarity();
    testIdle();
    testBitRuns();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule